// File: doc/BRIEF.md
# Quad-Data-Rate Burst-Four SRAM Model

This block is a synthesizable behavioural model of a static memory with a read data port and a write data port that work independently, fed by one shared address bus. Every address names a group of four words. A group is always moved as a four-beat burst, one word on each edge of a complementary clock pair. Here one fast clock `clk` stands for both edges. The block makes its own phase bit, which tells whether the next rising `clk` edge is a true-clock edge or a complementary-clock edge.

A read request and a write request may start on the same true-clock edge. The read address is taken on that true edge. The write address is taken on the complementary edge that follows it. The write's four data beats and byte-lane enables come in on four consecutive edges, and the group is updated once the last beat has arrived. The read returns its four words after a fixed, parameterised number of edges, marked by a valid flag, together with an output-enable that models the tri-state behaviour of the data pins. A read always returns the array contents as they stood on its own capture edge.

Top module: `qdr_b4_sram`

## Requirements
- R1: During synchronous reset the array clears to zero, `k_phase` is 0, and `q_valid`, `q_oe` and `q_data` are low. After reset `k_phase` toggles on every `clk` edge. An edge taken while `k_phase` is 0 is a true-clock edge. The first edge after reset is a true-clock edge.
- R2: When `rd_sel_n` is low on a true-clock edge and the read port is free, the group at `addr` is read. Word k (k = 0..3) appears on `q_data` after the edge that lies RD_LAT+k edges after the capture edge, with `q_valid` high on exactly those four edges.
- R3: When `wr_sel_n` is low on a true-clock edge and the write port is free, that edge takes data word 0. The next edge (complementary) takes the group address from `addr` and word 1. The two edges after that take words 2 and 3. The stored group changes only at the edge that takes word 3.
- R4: Byte lane l covers data bits 9l+8 down to 9l (lane 0 = bits 8:0, lane 3 = bits 35:27). `wr_be_n[l]` is sampled with each word. When it is low, that lane of that word is written. When it is high, that lane of that word keeps its stored value.
- R5: A port whose select is high on a true-clock edge starts no access, and the values on `addr`, `wr_data` and `wr_be_n` then change nothing.
- R6: A select that is low on the true-clock edge in the middle of that port's own burst (two edges after acceptance) is ignored. A port is free again four edges after acceptance, so each port can start one burst on every other true-clock edge.
- R7: A read returns the contents as of its capture edge. A write to the same group that was accepted on the same true edge, or whose last word has not yet arrived, leaves the read with the old data.
- R8: `q_data` is all zero whenever `q_valid` is low.
- R9: `q_oe` is high on every edge on which `q_valid` is high. After the last beat, `q_oe` stays high until the next true-clock edge with no beat and falls on that edge, so it never falls on a complementary edge.
- R10: A read burst and a write burst may run at the same time. Back-to-back requests on both ports, every other true-clock edge, are all served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; each rising edge stands for one edge of the complementary pair |
| rst_n | input | 1 | Synchronous active-low reset |
| k_phase | output | 1 | 0 when the next edge is a true-clock edge, 1 when it is a complementary edge |
| addr | input | AW | Shared group address: read address on true edges, write address on the edge after a write start |
| rd_sel_n | input | 1 | Active-low read request, sampled on true edges |
| wr_sel_n | input | 1 | Active-low write request, sampled on true edges |
| wr_data | input | DW | Write data word, one per edge during a write burst |
| wr_be_n | input | NLANE | Active-low byte-lane write enables, one per 9-bit lane, sampled with each word |
| q_data | output | DW | Read data word |
| q_valid | output | 1 | High on the four edges that carry read data |
| q_oe | output | 1 | Output-enable, models the read data drivers being active |

## Verification
The assertions watch, on every cycle, the properties that involve no history beyond a cycle or two. They check that the phase alternates, that the array is only written on complementary edges, that data is zero outside beats, that `q_oe` covers `q_valid` and only drops on true edges, and that a burst never lasts a single beat. What only the bench scenarios can show is the content: that the right word of the right group arrives at the right latency, that partial lane enables merge correctly, that deselected or mid-burst requests leave the array untouched, and that a read overlapping a write to the same group returns old data.

// File: rtl/qdr_pkg.sv
// Shared constants for the burst-four memory model.
// Assumes the data width is a whole number of 9-bit lanes.
package qdr_pkg;
    localparam int unsigned BURST  = 4;
    localparam int unsigned LANE_W = 9;
    localparam int unsigned BEAT_W = $clog2(BURST);
endpackage

// File: rtl/qdr_store.sv
// Group-organised storage: each row holds BURST words of DW bits.
// Writes a whole group in one cycle with per-word, per-lane enables;
// reads a whole group combinationally. Assumes DEPTH is a power of two.
module qdr_store #(
    parameter int DW    = 36,
    parameter int DEPTH = 16,
    localparam int NLANE = DW / qdr_pkg::LANE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [AW-1:0]                          w_addr,
    input  logic [qdr_pkg::BURST-1:0][DW-1:0]      w_grp,
    input  logic [qdr_pkg::BURST-1:0][NLANE-1:0]   w_ben,
    input  logic [AW-1:0]                          r_addr,
    output logic [qdr_pkg::BURST-1:0][DW-1:0]      r_grp
);
    import qdr_pkg::*;

    logic [BURST-1:0][DW-1:0] mem [DEPTH];

    // Clear on reset, else merge enabled lanes of all words into one row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            for (int k = 0; k < BURST; k++) begin
                for (int l = 0; l < NLANE; l++) begin
                    if (!w_ben[k][l]) begin
                        mem[w_addr][k][l*LANE_W +: LANE_W] <= w_grp[k][l*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    // Present the addressed group to the read side.
    always_comb begin
        r_grp = mem[r_addr];
    end
endmodule

// File: rtl/qdr_wr_ctl.sv
// Write burst collector. Starts on a true edge with the select low,
// takes the group address on the following edge, gathers four words
// with their lane enables and asks for a commit on the fourth edge.
// Assumes true edges alternate with complementary edges.
module qdr_wr_ctl #(
    parameter int DW    = 36,
    parameter int DEPTH = 16,
    localparam int NLANE = DW / qdr_pkg::LANE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   true_edge,
    input  logic                                   sel_n,
    input  logic [AW-1:0]                          addr,
    input  logic [DW-1:0]                          data,
    input  logic [NLANE-1:0]                       ben,
    output logic                                   we,
    output logic [AW-1:0]                          w_addr,
    output logic [qdr_pkg::BURST-1:0][DW-1:0]      w_grp,
    output logic [qdr_pkg::BURST-1:0][NLANE-1:0]   w_ben
);
    import qdr_pkg::*;

    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST - 1);

    logic                          act;
    logic [BEAT_W-1:0]             beat;
    logic [BURST-2:0][DW-1:0]      held;
    logic [BURST-2:0][NLANE-1:0]   held_be;
    logic [AW-1:0]                 a_q;
    logic                          accept;

    // A new burst only starts on a true edge while no burst is open.
    always_comb begin
        accept = true_edge && !sel_n && !act;
    end

    // Track the beat, latch the address on beat 1 and hold early words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= 1'b0;
            beat    <= '0;
            held    <= '0;
            held_be <= '0;
            a_q     <= '0;
        end else if (accept) begin
            act        <= 1'b1;
            beat       <= BEAT_W'(1);
            held[0]    <= data;
            held_be[0] <= ben;
        end else if (act) begin
            if (beat == BEAT_W'(1)) begin
                a_q <= addr;
            end
            if (beat != LAST) begin
                held[beat]    <= data;
                held_be[beat] <= ben;
            end else begin
                act <= 1'b0;
            end
            beat <= beat + BEAT_W'(1);
        end
    end

    // Commit request: the last word comes straight from the inputs.
    always_comb begin
        we     = act && (beat == LAST);
        w_addr = a_q;
        w_grp  = {data, held};
        w_ben  = {ben, held_be};
    end
endmodule

// File: rtl/qdr_rd_ctl.sv
// Read burst generator. Captures a full group on a true edge, plays its
// words out on consecutive edges, delays them by RD_LAT edges in total
// and produces valid and output-enable. Assumes RD_LAT >= 1.
module qdr_rd_ctl #(
    parameter int DW     = 36,
    parameter int RD_LAT = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               true_edge,
    input  logic                               sel_n,
    input  logic [qdr_pkg::BURST-1:0][DW-1:0]  grp,
    output logic [DW-1:0]                      q_data,
    output logic                               q_valid,
    output logic                               q_oe
);
    import qdr_pkg::*;

    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST - 1);

    logic                      act;
    logic [BEAT_W-1:0]         beat;
    logic [BURST-1:0][DW-1:0]  snap;
    logic                      accept;
    logic                      seq_v;
    logic [DW-1:0]             seq_d;
    logic                      nxt_v;
    logic                      pv [1:RD_LAT];
    logic [DW-1:0]             pd [1:RD_LAT];
    logic                      oe_q;

    // Accept on a true edge when idle or when the last beat is leaving.
    always_comb begin
        accept = true_edge && !sel_n && (!act || beat == LAST);
    end

    // Snapshot the group at capture and step through its words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            beat <= '0;
            snap <= '0;
        end else if (accept) begin
            act  <= 1'b1;
            beat <= '0;
            snap <= grp;
        end else if (act) begin
            if (beat == LAST) begin
                act <= 1'b0;
            end
            beat <= beat + BEAT_W'(1);
        end
    end

    // Current sequencer word, zero when no beat is due.
    always_comb begin
        seq_v = act;
        seq_d = act ? snap[beat] : '0;
    end

    // Delay line that sets the read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= RD_LAT; i++) begin
                pv[i] <= 1'b0;
                pd[i] <= '0;
            end
        end else begin
            pv[1] <= seq_v;
            pd[1] <= seq_d;
            for (int i = 2; i <= RD_LAT; i++) begin
                pv[i] <= pv[i-1];
                pd[i] <= pd[i-1];
            end
        end
    end

    // Value q_valid will take after the coming edge.
    generate
        if (RD_LAT == 1) begin : g_lat_one
            assign nxt_v = seq_v;
        end else begin : g_lat_many
            assign nxt_v = pv[RD_LAT-1];
        end
    endgenerate

    // Enable rises with a beat and only drops on a true edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (nxt_v) begin
            oe_q <= 1'b1;
        end else if (true_edge) begin
            oe_q <= 1'b0;
        end
    end

    // Drive the outputs from the end of the delay line.
    always_comb begin
        q_valid = pv[RD_LAT];
        q_data  = pd[RD_LAT];
        q_oe    = oe_q;
    end
endmodule

// File: rtl/qdr_b4_sram.sv
// Top of the burst-four memory model. Generates the edge phase, routes
// the shared address to both ports and joins the read and write paths
// to one group store. Assumes one clk edge per edge of the modelled pair.
module qdr_b4_sram #(
    parameter int DW     = 36,
    parameter int DEPTH  = 16,
    parameter int RD_LAT = 3,
    localparam int NLANE = DW / qdr_pkg::LANE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               k_phase,
    input  logic [AW-1:0]      addr,
    input  logic               rd_sel_n,
    input  logic               wr_sel_n,
    input  logic [DW-1:0]      wr_data,
    input  logic [NLANE-1:0]   wr_be_n,
    output logic [DW-1:0]      q_data,
    output logic               q_valid,
    output logic               q_oe
);
    import qdr_pkg::*;

    logic                         ph_q;
    logic                         true_edge;
    logic                         st_we;
    logic [AW-1:0]                st_waddr;
    logic [BURST-1:0][DW-1:0]     st_wgrp;
    logic [BURST-1:0][NLANE-1:0]  st_wben;
    logic [BURST-1:0][DW-1:0]     st_rgrp;

    // Alternate between true and complementary edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
        end
    end

    // Phase out and the true-edge strobe used by both ports.
    always_comb begin
        k_phase   = ph_q;
        true_edge = ~ph_q;
    end

    qdr_wr_ctl #(.DW(DW), .DEPTH(DEPTH)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .true_edge (true_edge),
        .sel_n     (wr_sel_n),
        .addr      (addr),
        .data      (wr_data),
        .ben       (wr_be_n),
        .we        (st_we),
        .w_addr    (st_waddr),
        .w_grp     (st_wgrp),
        .w_ben     (st_wben)
    );

    qdr_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (st_we),
        .w_addr (st_waddr),
        .w_grp  (st_wgrp),
        .w_ben  (st_wben),
        .r_addr (addr),
        .r_grp  (st_rgrp)
    );

    qdr_rd_ctl #(.DW(DW), .RD_LAT(RD_LAT)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .true_edge (true_edge),
        .sel_n     (rd_sel_n),
        .grp       (st_rgrp),
        .q_data    (q_data),
        .q_valid   (q_valid),
        .q_oe      (q_oe)
    );
endmodule

// File: rtl/qdr_b4_sram_chk.sv
// Cycle-level properties of the burst-four memory model, bound to the top.
// Assumes reset is held low for at least one clock at start-up.
module qdr_b4_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          k_phase,
    input logic          st_we,
    input logic [DW-1:0] q_data,
    input logic          q_valid,
    input logic          q_oe
);
    // R1: phase alternates on every edge once out of reset
    p_phase_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (k_phase != $past(k_phase)));

    // R3: the array is only committed on a complementary edge
    p_commit_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> k_phase);

    // R8: no data outside beats
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (q_data == '0));

    // R9: enable covers every beat
    p_oe_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> q_oe);

    // R9: enable falls only on a true edge
    p_oe_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_oe) |-> !$past(k_phase));

    // R2: a burst never ends after one beat
    p_burst_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_valid) |=> q_valid);
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .k_phase (k_phase),
    .st_we   (st_we),
    .q_data  (q_data),
    .q_valid (q_valid),
    .q_oe    (q_oe)
);

// File: tb/qdr_b4_sram_bench.sv
module qdr_b4_sram_bench;
    localparam int DW    = 36;
    localparam int DEPTH = 16;
    localparam int LAT   = 3;
    localparam int NL    = DW / 9;
    localparam int AW    = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            k_phase;
    logic [AW-1:0]   b_addr = '0;
    logic            b_rsel_n = 1'b1;
    logic            b_wsel_n = 1'b1;
    logic [DW-1:0]   b_wdata = '0;
    logic [NL-1:0]   b_ben = '1;
    logic [DW-1:0]   q_data;
    logic            q_valid;
    logic            q_oe;

    always #5 clk = ~clk;

    qdr_b4_sram #(.DW(DW), .DEPTH(DEPTH), .RD_LAT(LAT)) u_qdr_b4_sram (
        .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .addr(b_addr),
        .rd_sel_n(b_rsel_n), .wr_sel_n(b_wsel_n), .wr_data(b_wdata),
        .wr_be_n(b_ben), .q_data(q_data), .q_valid(q_valid), .q_oe(q_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit armed = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [DW-1:0] mem_m [0:DEPTH*4-1];
    bit            ring_v [0:31];
    logic [DW-1:0] ring_d [0:31];
    int            e_idx;
    int            rd_free_at;
    int            w_cnt;
    int            w_addr_m;
    logic [DW-1:0] wb [0:3];
    logic [NL-1:0] wbe [0:3];
    bit            m_ph, m_oe, e_v, e_ph;
    logic [DW-1:0] e_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH*4; i++) mem_m[i] = '0;
            for (int i = 0; i < 32; i++) begin ring_v[i] = 1'b0; ring_d[i] = '0; end
            e_idx = 0; rd_free_at = 0; w_cnt = -1; w_addr_m = 0;
            m_ph = 1'b0; m_oe = 1'b0; e_v = 1'b0; e_d = '0; e_ph = 1'b0;
            armed = 1'b1;
        end else begin
            bit tru;
            tru = (m_ph == 1'b0);
            if (tru && !b_rsel_n && e_idx >= rd_free_at) begin
                for (int k = 0; k < 4; k++) begin
                    ring_v[(e_idx + LAT + k) % 32] = 1'b1;
                    ring_d[(e_idx + LAT + k) % 32] = mem_m[int'(b_addr)*4 + k];
                end
                rd_free_at = e_idx + 4;
            end
            if (w_cnt == -1) begin
                if (tru && !b_wsel_n) begin
                    wb[0] = b_wdata; wbe[0] = b_ben; w_cnt = 1;
                end
            end else begin
                if (w_cnt == 1) w_addr_m = int'(b_addr);
                wb[w_cnt] = b_wdata; wbe[w_cnt] = b_ben;
                if (w_cnt == 3) begin
                    for (int k = 0; k < 4; k++)
                        for (int l = 0; l < NL; l++)
                            if (!wbe[k][l]) mem_m[w_addr_m*4 + k][l*9 +: 9] = wb[k][l*9 +: 9];
                    w_cnt = -1;
                end else begin
                    w_cnt = w_cnt + 1;
                end
            end
            e_v = ring_v[e_idx % 32];
            e_d = e_v ? ring_d[e_idx % 32] : '0;
            ring_v[e_idx % 32] = 1'b0;
            if (e_v) m_oe = 1'b1;
            else if (tru) m_oe = 1'b0;
            m_ph = ~m_ph;
            e_ph = m_ph;
            e_idx = e_idx + 1;
        end
    end

    task automatic cmp(input string tag, input string nm, input logic [DW-1:0] a, input logic [DW-1:0] e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s (scenario %s) %s actual=%h expected=%h at %0t", tag, cur_req, nm, a, e, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            cmp("R1", "k_phase", DW'(k_phase), DW'(e_ph));
            cmp("R2", "q_valid", DW'(q_valid), DW'(e_v));
            cmp("R9", "q_oe", DW'(q_oe), DW'(m_oe));
            cmp(e_v ? "R2" : "R8", "q_data", q_data, e_d);
        end
    end

    function automatic logic [DW-1:0] word_of(input logic [DW-1:0] base, input int k);
        return base + DW'(k) * 36'h111111111;
    endfunction

    function automatic logic [NL-1:0] be_of(input logic [NL-1:0] be0, input int k);
        return NL'((be0 << k) | (be0 >> (NL - k)));
    endfunction

    // One request slot: four edges starting on a true edge
    task automatic issue(input bit do_rd, input int ra, input bit do_wr, input int wa,
                         input logic [DW-1:0] base, input logic [NL-1:0] be0, input bit stray);
        while (k_phase !== 1'b0) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            b_wdata = word_of(base, k);
            b_ben   = be_of(be0, k);
            case (k)
                0: begin b_rsel_n = !do_rd; b_wsel_n = !do_wr; b_addr = AW'(ra); end
                1: begin b_rsel_n = 1'b1; b_wsel_n = 1'b1; b_addr = AW'(wa); end
                2: begin b_rsel_n = !stray; b_wsel_n = !stray; b_addr = AW'(~ra); end
                default: begin b_rsel_n = 1'b1; b_wsel_n = 1'b1; b_addr = AW'(ra + 7); end
            endcase
            @(negedge clk);
        end
        b_rsel_n = 1'b1; b_wsel_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            b_rsel_n = 1'b1; b_wsel_n = 1'b1;
            b_addr = AW'($urandom); b_wdata = {$urandom, $urandom} & {DW{1'b1}};
            b_ben = NL'($urandom);
            @(negedge clk);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R3";   // plain writes, then reads of them
        issue(0, 0, 1, 1, 36'h0_0000_0100, 4'b0000, 0);
        issue(0, 0, 1, 2, 36'h5_A5A5_0200, 4'b0000, 0);
        cur_req = "R2";
        issue(1, 1, 0, 0, '0, 4'b1111, 0);
        issue(1, 2, 0, 0, '0, 4'b1111, 0);
        issue(1, 0, 0, 0, '0, 4'b1111, 0);
        idle(8);

        cur_req = "R4";   // partial lanes, rotating per word
        issue(0, 0, 1, 1, 36'hF_0F0F_0F0F, 4'b0101, 0);
        issue(0, 0, 1, 1, 36'h3_3333_3333, 4'b1110, 0);
        issue(0, 0, 1, 1, 36'hC_C000_0000, 4'b1111, 0);
        issue(1, 1, 0, 0, '0, 4'b1111, 0);
        idle(8);

        cur_req = "R7";   // same group read and written in one slot
        issue(1, 2, 1, 2, 36'h7_7777_0000, 4'b0000, 0);
        issue(1, 2, 0, 0, '0, 4'b1111, 0);
        idle(8);

        cur_req = "R5";   // deselected noise, then read back
        idle(16);
        issue(1, 1, 0, 0, '0, 4'b1111, 0);
        issue(1, 2, 0, 0, '0, 4'b1111, 0);
        idle(8);

        cur_req = "R6";   // selects low again mid-burst
        issue(1, 3, 1, 3, 36'h9_0000_1234, 4'b0000, 1);
        issue(1, 3, 0, 0, '0, 4'b1111, 0);
        issue(1, 12, 0, 0, '0, 4'b1111, 0);
        idle(8);

        cur_req = "R10";  // both ports at full rate
        for (int i = 0; i < 16; i++)
            issue(1, i, 1, (i + 5) % 16, DW'(i) * 36'h0_1003_0507, NL'(i), 0);
        for (int i = 0; i < 16; i++)
            issue(1, i, 0, 0, '0, 4'b1111, 0);
        idle(8);

        cur_req = "R2";   // mixed random traffic
        for (int i = 0; i < 150; i++) begin
            bit r, w;
            r = 1'($urandom); w = 1'($urandom);
            issue(r, int'($urandom % DEPTH), w, int'($urandom % DEPTH),
                  {$urandom, $urandom} & {DW{1'b1}}, NL'($urandom), r & w & 1'($urandom));
            if ($urandom % 4 == 0) idle(int'($urandom % 3) + 1);
        end
        idle(12);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule